// File: doc/BRIEF.md
# Streaming Image Checksum Unit

This block forms the 16-bit verification checksum of a memory image that arrives as a stream of words, one word per clock. A start pulse opens a new computation and clears everything left from the previous one. The protection selection is captured on that same pulse. Each following word carries a tag. The tag marks the word as a program word, a configuration word or a user identifier word. The word that carries the last flag closes the stream, and one cycle later the block raises a single-cycle done flag with the finished sum on its output.

Program words are added at full width. Configuration words are first ANDed with the parameter `CFG_MASK`. From each user identifier word only the low nibble is kept. Those nibbles are packed into one 16-bit value, with the first identifier in the most significant nibble. When protection is selected, the packed identifier value replaces the program-word total, and the masked configuration total is still added. All arithmetic wraps at 16 bits.

Control is a three-state machine:
- IDLE: waiting for a start pulse. IDLE to ACCUM on a start pulse.
- ACCUM: accepting words. ACCUM to ACCUM on a repeated start pulse, which restarts the computation. ACCUM to DONE on an accepted word with the last flag set.
- DONE: one cycle with done asserted. DONE to IDLE on the next edge, or DONE to ACCUM if a start pulse is present in that cycle.

Top module: `imgsum_unit`

## Requirements
- R1: A start pulse (`start_i` high for one cycle) clears the sum and all partial totals. After the next clock edge `sum_o` reads 0 and `done_o` is low.
- R2: Words with tag 0 (program) are added at their full 14-bit value. The total wraps modulo 2^16, and carries out of bit 15 are lost.
- R3: A word with tag 1 (configuration) is ANDed with `CFG_MASK` before it is added. With the default mask 0x31FF, bits 9 to 11 of such a word never reach the sum.
- R4: A word with tag 2 (user identifier) contributes only bits 3:0. The first four such words fill nibbles [15:12], [11:8], [7:4] and [3:0] in arrival order. Identifier words after the fourth are dropped, and nibbles that receive no identifier stay 0.
- R5: `protect_i` is sampled with the start pulse. If it was 1, the result is the packed identifier value plus the masked configuration total, and program words have no effect. If it was 0, the result is the program total plus the masked configuration total, and identifier words have no effect.
- R6: When a word with `in_valid_i` and `in_last_i` high is accepted, that word is included in the result. `done_o` is high for exactly the next cycle, and `sum_o` shows the result from that cycle on.
- R7: Words are ignored when `in_valid_i` is low, when the tag is 3, or when they arrive outside a stream (before any start pulse or after done). `sum_o` holds its value until the next start pulse.
- R8: A start pulse in the middle of a stream discards every word accepted before it. A word presented in the same cycle as the start pulse is also discarded.
- R9: After reset, `sum_o` is 0, `done_o` is low and the machine is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse: clears and opens a stream |
| protect_i | input | 1 | Protection select, sampled with start_i |
| in_valid_i | input | 1 | Input word valid |
| in_tag_i | input | 2 | 0 program, 1 configuration, 2 user identifier, 3 ignored |
| in_data_i | input | WORD_W (14) | Input word |
| in_last_i | input | 1 | Marks the final word of the stream |
| sum_o | output | SUM_W (16) | Checksum result |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench sweeps stream lengths up to overflow, so a design that saturated or kept a 17th bit would give the wrong total. It sets every configuration bit one at a time, which exposes a mask that is missing or shifted. It also sweeps all sixteen nibble values through each identifier position, with junk in the upper bits, which catches a reversed nibble order, an unmasked identifier, or a fifth identifier that overwrites the first. Further streams flip the protection choice and check that the excluded source is truly ignored. Restarts in the middle of a stream, a word that coincides with the start pulse, and words that arrive while idle show whether a design leaks stale totals or raises a spurious done.

// File: rtl/imgsum_pkg.sv
package imgsum_pkg;
    typedef enum logic [1:0] {
        TAG_PROG = 2'd0,
        TAG_CFG  = 2'd1,
        TAG_UID  = 2'd2,
        TAG_NONE = 2'd3
    } word_tag_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/imgsum_ctrl.sv
module imgsum_ctrl
    import imgsum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic in_valid_i,
    input  logic in_last_i,
    output logic take_o,
    output logic finish_o,
    output logic done_o
);
    ctrl_state_e state_q, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_nx = ST_ACCUM;
            ST_ACCUM: begin
                if (start_i)                       state_nx = ST_ACCUM;
                else if (in_valid_i && in_last_i)  state_nx = ST_DONE;
            end
            ST_DONE:  state_nx = start_i ? ST_ACCUM : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        take_o   = (state_q == ST_ACCUM) && in_valid_i && !start_i;
        finish_o = take_o && in_last_i;
        done_o   = (state_q == ST_DONE);
    end
endmodule

// File: rtl/imgsum_accum.sv
module imgsum_accum
    import imgsum_pkg::*;
#(
    parameter int                 WORD_W   = 14,
    parameter int                 SUM_W    = 16,
    parameter logic [WORD_W-1:0]  CFG_MASK = 14'h31FF,
    parameter int                 ID_COUNT = 4,
    parameter int                 NIB_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              protect_i,
    input  logic              take_i,
    input  logic              finish_i,
    input  logic [1:0]        tag_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [SUM_W-1:0]  sum_o
);
    localparam int PACK_W = ID_COUNT * NIB_W;
    localparam int CNT_W  = $clog2(ID_COUNT + 1);

    word_tag_e           tag_e;
    logic [SUM_W-1:0]    prog_q, prog_nx;
    logic [SUM_W-1:0]    cfg_q, cfg_nx;
    logic [PACK_W-1:0]   uid_q, uid_nx;
    logic [CNT_W-1:0]    id_cnt_q;
    logic                prot_q;
    logic [SUM_W-1:0]    result;
    logic                uid_hit;

    assign tag_e   = word_tag_e'(tag_i);
    assign uid_hit = take_i && (tag_e == TAG_UID) && (id_cnt_q < CNT_W'(ID_COUNT));

    always_comb begin
        prog_nx = prog_q;
        cfg_nx  = cfg_q;
        if (take_i && tag_e == TAG_PROG) prog_nx = prog_q + SUM_W'(data_i);
        if (take_i && tag_e == TAG_CFG)  cfg_nx  = cfg_q + SUM_W'(data_i & CFG_MASK);
    end

    // One nibble slot per identifier; first identifier lands in the top slot
    for (genvar g = 0; g < ID_COUNT; g++) begin : g_slot
        assign uid_nx[g*NIB_W +: NIB_W] =
            (uid_hit && id_cnt_q == CNT_W'(ID_COUNT - 1 - g)) ?
            data_i[NIB_W-1:0] : uid_q[g*NIB_W +: NIB_W];
    end

    assign result = (prot_q ? SUM_W'(uid_nx) : prog_nx) + cfg_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q   <= '0;
            cfg_q    <= '0;
            uid_q    <= '0;
            id_cnt_q <= '0;
            prot_q   <= 1'b0;
            sum_o    <= '0;
        end else if (clear_i) begin
            prog_q   <= '0;
            cfg_q    <= '0;
            uid_q    <= '0;
            id_cnt_q <= '0;
            prot_q   <= protect_i;
            sum_o    <= '0;
        end else begin
            prog_q <= prog_nx;
            cfg_q  <= cfg_nx;
            uid_q  <= uid_nx;
            if (uid_hit) id_cnt_q <= id_cnt_q + 1'b1;
            if (finish_i) sum_o <= result;
        end
    end
endmodule

// File: rtl/imgsum_unit.sv
module imgsum_unit
    import imgsum_pkg::*;
#(
    parameter int                 WORD_W   = 14,
    parameter int                 SUM_W    = 16,
    parameter logic [WORD_W-1:0]  CFG_MASK = 14'h31FF,
    parameter int                 ID_COUNT = 4,
    parameter int                 NIB_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              protect_i,
    input  logic              in_valid_i,
    input  logic [1:0]        in_tag_i,
    input  logic [WORD_W-1:0] in_data_i,
    input  logic              in_last_i,
    output logic [SUM_W-1:0]  sum_o,
    output logic              done_o
);
    logic take, finish;

    imgsum_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .in_last_i  (in_last_i),
        .take_o     (take),
        .finish_o   (finish),
        .done_o     (done_o)
    );

    imgsum_accum #(
        .WORD_W   (WORD_W),
        .SUM_W    (SUM_W),
        .CFG_MASK (CFG_MASK),
        .ID_COUNT (ID_COUNT),
        .NIB_W    (NIB_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .protect_i (protect_i),
        .take_i    (take),
        .finish_i  (finish),
        .tag_i     (in_tag_i),
        .data_i    (in_data_i),
        .sum_o     (sum_o)
    );
endmodule

// File: rtl/imgsum_chk.sv
module imgsum_chk #(
    parameter int SUM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_valid_i,
    input logic             in_last_i,
    input logic [SUM_W-1:0] sum_o,
    input logic             done_o
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sum_o == '0 && !done_o)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(in_valid_i && in_last_i && !start_i)); // R6

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(in_valid_i && in_last_i)) |=> $stable(sum_o)); // R7
endmodule

bind imgsum_unit imgsum_chk #(.SUM_W(SUM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .sum_o      (sum_o),
    .done_o     (done_o)
);

// File: tb/imgsum_unit_bench.sv
module imgsum_unit_bench;
    localparam int          WORD_W   = 14;
    localparam int          SUM_W    = 16;
    localparam logic [13:0] CFG_MASK = 14'h31FF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              protect_i = 1'b0;
    logic              in_valid_i = 1'b0;
    logic [1:0]        in_tag_i = 2'd0;
    logic [WORD_W-1:0] in_data_i = '0;
    logic              in_last_i = 1'b0;
    logic [SUM_W-1:0]  sum_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    // Reference totals, computed arithmetically
    int          ref_prog, ref_cfg, ref_n;
    logic [15:0] ref_uid;
    bit          ref_prot;

    always #10 clk = ~clk;

    imgsum_unit #(
        .WORD_W(WORD_W), .SUM_W(SUM_W), .CFG_MASK(CFG_MASK),
        .ID_COUNT(4), .NIB_W(4)
    ) u_imgsum_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .protect_i(protect_i),
        .in_valid_i(in_valid_i), .in_tag_i(in_tag_i), .in_data_i(in_data_i),
        .in_last_i(in_last_i), .sum_o(sum_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int expected_sum();
        int base;
        base = ref_prot ? int'(ref_uid) : ref_prog;
        return (base + ref_cfg) % 65536;
    endfunction

    task automatic begin_stream(input bit prot);
        @(negedge clk);
        start_i = 1'b1; protect_i = prot;
        in_valid_i = 1'b0; in_last_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        ref_prog = 0; ref_cfg = 0; ref_n = 0; ref_uid = 16'h0; ref_prot = prot;
        check("R1 sum cleared", int'(sum_o), 0);
        check("R1 done low", int'(done_o), 0);
    endtask

    task automatic model(input logic [1:0] tag, input logic [13:0] data);
        case (tag)
            2'd0: ref_prog = (ref_prog + int'(data)) % 65536;
            2'd1: ref_cfg  = (ref_cfg + int'(data & CFG_MASK)) % 65536;
            2'd2: if (ref_n < 4) begin
                      ref_uid[(3 - ref_n)*4 +: 4] = data[3:0];
                      ref_n++;
                  end
            default: ;
        endcase
    endtask

    task automatic push(input logic [1:0] tag, input logic [13:0] data,
                        input bit last, input string req);
        int exp;
        if (!last) begin
            // An idle cycle with valid low and junk data first: must be ignored (R7)
            @(negedge clk);
            in_valid_i = 1'b0; in_tag_i = tag; in_data_i = ~data; in_last_i = 1'b1;
        end
        @(negedge clk);
        in_valid_i = 1'b1; in_tag_i = tag; in_data_i = data; in_last_i = last;
        model(tag, data);
        if (last) begin
            @(negedge clk);
            in_valid_i = 1'b0; in_last_i = 1'b0;
            exp = expected_sum();
            check({req, " R6 done"}, int'(done_o), 1);
            check({req, " sum"}, int'(sum_o), exp);
            @(negedge clk);
            check("R6 done one cycle", int'(done_o), 0);
            check("R6 sum held", int'(sum_o), exp);
        end
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] held;
        repeat (3) @(negedge clk);
        check("R9 reset sum", int'(sum_o), 0);
        check("R9 reset done", int'(done_o), 0);
        rst_n = 1'b1;

        // R7: words before any start are ignored
        @(negedge clk);
        in_valid_i = 1'b1; in_tag_i = 2'd0; in_data_i = 14'h123; in_last_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 no done while idle", int'(done_o), 0);
        check("R7 sum unchanged while idle", int'(sum_o), 0);
        in_valid_i = 1'b0; in_last_i = 1'b0;

        // R2: stream lengths 1..12, including wrap past 16 bits
        for (int n = 1; n <= 12; n++) begin
            begin_stream(1'b0);
            for (int k = 0; k < n; k++)
                push(2'd0, 14'((n * 4099 + k * 7919) & 14'h3FFF), k == n - 1, "R2 program sum");
        end
        begin_stream(1'b0);
        for (int k = 0; k < 6; k++) push(2'd0, 14'h3FFF, k == 5, "R2 wrap");

        // R3: every configuration bit alone, plus all ones
        for (int b = 0; b < 14; b++) begin
            begin_stream(1'b0);
            push(2'd0, 14'd1, 1'b0, "R3 mask");
            push(2'd1, 14'(1 << b), 1'b1, "R3 mask");
        end
        begin_stream(1'b0);
        push(2'd1, 14'h3FFF, 1'b0, "R3 mask");
        push(2'd1, 14'h3FFF, 1'b1, "R3 two config words");

        // R4/R5: nibble sweep with protection on and junk upper bits
        for (int v = 0; v < 16; v++) begin
            begin_stream(1'b1);
            push(2'd0, 14'h2AAA, 1'b0, "R5 program ignored");
            push(2'd2, 14'(14'h3AB0 | v), 1'b0, "R4");
            push(2'd2, 14'(14'h1C50 | (v ^ 5)), 1'b0, "R4");
            push(2'd2, 14'(14'h0FF0 | (15 - v)), 1'b0, "R4");
            push(2'd2, 14'(14'h2220 | ((v + 3) & 15)), 1'b0, "R4");
            push(2'd2, 14'h000F, 1'b0, "R4 fifth id dropped");
            push(2'd1, 14'h0E05, 1'b1, "R4 packed ids");
        end
        begin_stream(1'b1);
        push(2'd2, 14'h0009, 1'b0, "R4");
        push(2'd2, 14'h0006, 1'b1, "R4 missing ids zero");

        // R5: protection off, identifier words have no effect
        begin_stream(1'b0);
        push(2'd2, 14'h000F, 1'b0, "R5");
        push(2'd0, 14'h0100, 1'b0, "R5");
        push(2'd1, 14'h0003, 1'b1, "R5 ids ignored unprotected");

        // R7: tag 3 ignored
        begin_stream(1'b0);
        push(2'd0, 14'h0040, 1'b0, "R7");
        push(2'd3, 14'h1111, 1'b0, "R7");
        push(2'd0, 14'h0002, 1'b1, "R7 tag 3 ignored");

        // R7: words after done are ignored and sum holds
        held = sum_o;
        @(negedge clk);
        in_valid_i = 1'b1; in_tag_i = 2'd0; in_data_i = 14'h0777; in_last_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 no done after stream", int'(done_o), 0);
        check("R7 sum held after stream", int'(sum_o), int'(held));
        in_valid_i = 1'b0; in_last_i = 1'b0;

        // R8: restart mid-stream, and a word coinciding with start
        begin_stream(1'b0);
        push(2'd0, 14'h0500, 1'b0, "R8");
        push(2'd1, 14'h0011, 1'b0, "R8");
        @(negedge clk);
        start_i = 1'b1; protect_i = 1'b0;
        in_valid_i = 1'b1; in_tag_i = 2'd0; in_data_i = 14'h0123; in_last_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0;
        ref_prog = 0; ref_cfg = 0; ref_n = 0; ref_uid = 16'h0; ref_prot = 1'b0;
        check("R8 restart clears", int'(sum_o), 0);
        push(2'd0, 14'h0021, 1'b1, "R8 restart discards earlier words");

        // R8: start coinciding with a last word must not finish
        @(negedge clk);
        start_i = 1'b1; protect_i = 1'b0;
        in_valid_i = 1'b1; in_tag_i = 2'd0; in_data_i = 14'h0050; in_last_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
        @(negedge clk);
        check("R8 word with start dropped", int'(done_o), 0);
        ref_prog = 0; ref_cfg = 0; ref_n = 0; ref_uid = 16'h0; ref_prot = 1'b0;
        push(2'd0, 14'h0007, 1'b1, "R8 only later word counted");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule